// File: doc/BRIEF.md
# Receive DMA Burst Writer

This block drains a received packet from an on-block byte store into system memory through a request/grant write port. Software or a descriptor engine pulses `start` with the destination byte address. Packet bytes arrive one per cycle on the receive side, and the last byte carries an end flag. The store is organised as `DEPTH` 32-bit words. The writer holds back until half of that capacity is filled, then sends a burst of full words whose length is half the depth.

A destination address that is not word aligned is handled with single byte writes. Up to three are issued before the first word, and the same goes for the one to three bytes left over after the last whole word. When the packet end is in the store, the writer flushes whatever remains: a short word burst and then the tail bytes. It then gives a one-cycle completion pulse together with the number of bytes written. An error response on any accepted beat ends the packet at once. In that case the writer discards the stored bytes and raises an error pulse in place of completion.

Top module: `rx_dma_writer`

## Requirements
- R1: A write transfer is requested only when the store holds at least 2*DEPTH bytes, or when the packet's last byte is already in the store.
- R2: A word beat has `bus_be` = 4'b1111 and a word-aligned address. Lane k carries the byte for address base+k, so the lowest address is in bits 7:0. A burst carries at most DEPTH/2 beats, and it carries exactly DEPTH/2 whenever the packet end is not yet stored.
- R3: When the packet end is stored and fewer than DEPTH/2 whole words remain, they go out as one shorter burst.
- R4: Let a be the start address. Before the first word beat, min(len, (4 - a mod 4) mod 4) single byte writes are issued. Each has a one-hot `bus_be` selecting lane `bus_addr[1:0]` and carries its byte in that lane.
- R5: After the last word beat, the (len - head) mod 4 remaining bytes go out as single byte writes at increasing addresses.
- R6: With the packet end stored, all remaining bytes are written even though the store is below half full.
- R7: `bus_req` stays high exactly for the beats of one transfer and then goes low for at least one cycle. Every byte write is a separate transfer.
- R8: After the last byte is written, `done` is high for one cycle, and `done_bytes` holds the packet length in that cycle.
- R9: A beat accepted with `bus_err` high ends the packet. `err` pulses for one cycle, `done` is not raised, and the stored bytes are discarded. The next `start` proceeds normally.
- R10: `rx_ready` is low while the store holds 4*DEPTH bytes, and a byte offered then is not stored.
- R11: After reset, `bus_req`, `done` and `err` are low and `rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a packet; taken only when idle |
| start_addr | input | 32 | Destination byte address of the first packet byte |
| rx_valid | input | 1 | A packet byte is offered |
| rx_byte | input | 8 | Offered byte |
| rx_eop | input | 1 | Offered byte is the last of the packet |
| rx_ready | output | 1 | Store can take a byte this cycle |
| bus_req | output | 1 | Write transfer in progress |
| bus_gnt | input | 1 | Current beat is accepted at this edge |
| bus_err | input | 1 | Accepted beat failed |
| bus_addr | output | 32 | Beat byte address (word aligned for word beats) |
| bus_wdata | output | 32 | Beat data, lane k = byte at address base+k |
| bus_be | output | 4 | Byte lane enables |
| done | output | 1 | One-cycle packet completion pulse |
| done_bytes | output | 16 | Bytes written, valid with `done` |
| err | output | 1 | One-cycle packet abort pulse |

## Verification
The assertions assume several things about the stimulus. One packet is in flight at a time. Bytes of a following packet are not offered before the current one completes. `start` is pulsed only while the writer is idle, and a packet never exceeds 65535 bytes. The bench keeps to this by sending each packet in full and waiting for `done` or `err` before the next `start`. In the abort case it stores the whole packet before starting, so no byte arrives after the discard. It offers bytes only on cycles when it has seen `rx_ready`, except for one deliberate push into a full store.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_XFER,
        ST_GAP
    } rxdma_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [31:0]       data;
        logic [3:0]        be;
    } rxdma_beat_t;

    function automatic logic [3:0] lane_mask(input logic [1:0] lane);
        return 4'b0001 << lane;
    endfunction

    function automatic logic [31:0] place_byte(input logic [7:0] b, input logic [1:0] lane);
        return {24'd0, b} << {lane, 3'b000};
    endfunction

endpackage

// File: rtl/rxdma_byte_fifo.sv
module rxdma_byte_fifo #(
    parameter int DEPTH = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              push,
    input  logic [7:0]                        push_byte,
    input  logic                              push_eop,
    output logic                              ready,
    input  logic [2:0]                        pop_n,
    input  logic                              flush,
    input  logic                              clr_eop,
    output logic [31:0]                       peek,
    output logic [$clog2(DEPTH*4+1)-1:0]      count,
    output logic                              eop_seen
);
    localparam int NB = DEPTH * 4;
    localparam int PW = $clog2(NB);
    localparam int CW = $clog2(NB + 1);

    logic [7:0]    store [NB];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic          accept;

    assign ready  = (count < CW'(NB));
    assign accept = push && ready;

    always_ff @(posedge clk) begin
        if (accept) begin
            store[wr_ptr] <= push_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            eop_seen <= 1'b0;
        end else begin
            if (accept) begin
                wr_ptr <= wr_ptr + PW'(1);
            end
            rd_ptr <= rd_ptr + PW'(pop_n);
            count  <= count + CW'(accept) - CW'(pop_n);
            if (accept && push_eop) begin
                eop_seen <= 1'b1;
            end else if (clr_eop) begin
                eop_seen <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < 4; g++) begin : g_peek
        assign peek[8*g +: 8] = store[rd_ptr + PW'(g)];
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(NB)); // R10

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        CW'(pop_n) <= count); // R2

endmodule

// File: rtl/rxdma_beat_fmt.sv
module rxdma_beat_fmt
    import rxdma_pkg::*;
(
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              byte_mode,
    input  logic [31:0]       peek,
    output rxdma_beat_t       beat
);
    always_comb begin
        if (byte_mode) begin
            beat.addr = cur_addr;
            beat.be   = lane_mask(cur_addr[1:0]);
            beat.data = place_byte(peek[7:0], cur_addr[1:0]);
        end else begin
            beat.addr = {cur_addr[ADDR_W-1:2], 2'b00};
            beat.be   = 4'b1111;
            beat.data = peek;
        end
    end
endmodule

// File: rtl/rxdma_ctrl.sv
module rxdma_ctrl
    import rxdma_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [ADDR_W-1:0]             start_addr,
    input  logic [$clog2(DEPTH*4+1)-1:0]  fifo_count,
    input  logic                          eop_seen,
    input  logic                          bus_gnt,
    input  logic                          bus_err,
    output logic                          bus_req,
    output logic [ADDR_W-1:0]             cur_addr,
    output logic                          byte_mode,
    output logic [2:0]                    pop_n,
    output logic                          flush,
    output logic                          clr_eop,
    output logic                          done,
    output logic [LEN_W-1:0]              done_bytes,
    output logic                          err
);
    localparam int NB    = DEPTH * 4;
    localparam int CW    = $clog2(NB + 1);
    localparam int HALF  = NB / 2;
    localparam int BURST = DEPTH / 2;
    localparam int BW    = $clog2(BURST + 1);

    rxdma_state_e      state;
    logic [BW-1:0]     beats_left;
    logic [LEN_W-1:0]  total;
    logic [CW-1:0]     avail_words;
    logic [BW-1:0]     nwords;
    logic              go, finish, want_byte, beat, abort;
    logic [2:0]        step;

    assign avail_words = fifo_count >> 2;
    assign nwords      = (avail_words >= CW'(BURST)) ? BW'(BURST) : BW'(avail_words);
    assign go          = (fifo_count >= CW'(HALF)) || (eop_seen && fifo_count != '0);
    assign finish      = eop_seen && (fifo_count == '0);
    assign want_byte   = (cur_addr[1:0] != 2'b00) || (fifo_count < CW'(4));

    assign bus_req = (state == ST_XFER);
    assign beat    = bus_req && bus_gnt;
    assign abort   = beat && bus_err;
    assign step    = byte_mode ? 3'd1 : 3'd4;
    assign pop_n   = (beat && !bus_err) ? step : 3'd0;
    assign flush   = abort;
    assign clr_eop = (state == ST_WAIT) && finish;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cur_addr   <= '0;
            byte_mode  <= 1'b0;
            beats_left <= '0;
            total      <= '0;
            done       <= 1'b0;
            done_bytes <= '0;
            err        <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cur_addr <= start_addr;
                        total    <= '0;
                        state    <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (finish) begin
                        done       <= 1'b1;
                        done_bytes <= total;
                        state      <= ST_IDLE;
                    end else if (go) begin
                        byte_mode  <= want_byte;
                        beats_left <= want_byte ? BW'(1) : nwords;
                        state      <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (abort) begin
                        err   <= 1'b1;
                        state <= ST_IDLE;
                    end else if (beat) begin
                        cur_addr   <= cur_addr + ADDR_W'(step);
                        total      <= total + LEN_W'(step);
                        beats_left <= beats_left - BW'(1);
                        if (beats_left == BW'(1)) begin
                            state <= ST_GAP;
                        end
                    end
                end
                default: begin
                    state <= ST_WAIT;
                end
            endcase
        end
    end

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !byte_mode) |-> (cur_addr[1:0] == 2'b00)); // R2

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
        (beat && !bus_err && beats_left == BW'(1)) |=> !bus_req); // R7

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && err)); // R9

endmodule

// File: rtl/rx_dma_writer.sv
module rx_dma_writer
    import rxdma_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [31:0]          start_addr,
    input  logic                 rx_valid,
    input  logic [7:0]           rx_byte,
    input  logic                 rx_eop,
    output logic                 rx_ready,
    output logic                 bus_req,
    input  logic                 bus_gnt,
    input  logic                 bus_err,
    output logic [31:0]          bus_addr,
    output logic [31:0]          bus_wdata,
    output logic [3:0]           bus_be,
    output logic                 done,
    output logic [15:0]          done_bytes,
    output logic                 err
);
    localparam int NB   = DEPTH * 4;
    localparam int CW   = $clog2(NB + 1);
    localparam int HALF = NB / 2;

    logic [CW-1:0]     fifo_count;
    logic              eop_seen;
    logic [31:0]       peek;
    logic [2:0]        pop_n;
    logic              flush, clr_eop, byte_mode;
    logic [ADDR_W-1:0] cur_addr;
    rxdma_beat_t       beat;

    rxdma_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (rx_valid),
        .push_byte (rx_byte),
        .push_eop  (rx_eop),
        .ready     (rx_ready),
        .pop_n     (pop_n),
        .flush     (flush),
        .clr_eop   (clr_eop),
        .peek      (peek),
        .count     (fifo_count),
        .eop_seen  (eop_seen)
    );

    rxdma_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_addr (start_addr),
        .fifo_count (fifo_count),
        .eop_seen   (eop_seen),
        .bus_gnt    (bus_gnt),
        .bus_err    (bus_err),
        .bus_req    (bus_req),
        .cur_addr   (cur_addr),
        .byte_mode  (byte_mode),
        .pop_n      (pop_n),
        .flush      (flush),
        .clr_eop    (clr_eop),
        .done       (done),
        .done_bytes (done_bytes),
        .err        (err)
    );

    rxdma_beat_fmt u_fmt (
        .cur_addr  (cur_addr),
        .byte_mode (byte_mode),
        .peek      (peek),
        .beat      (beat)
    );

    assign bus_addr  = beat.addr;
    assign bus_wdata = beat.data;
    assign bus_be    = beat.be;

    AST_BURST_START: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> (fifo_count >= CW'(HALF) || eop_seen)); // R1

endmodule

// File: tb/tb_rx_dma_writer.sv
`timescale 1ns/1ps
module tb_rx_dma_writer;
    localparam int DEPTH = 16;
    localparam int BURST = DEPTH / 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_eop = 1'b0;
    logic        rx_ready;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic        bus_err = 1'b0;
    logic [31:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [3:0]  bus_be;
    logic        done;
    logic [15:0] done_bytes;
    logic        err;

    rx_dma_writer #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_eop(rx_eop), .rx_ready(rx_ready),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_err(bus_err),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .done(done), .done_bytes(done_bytes), .err(err)
    );

    always #2 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [7:0] mem [0:1023];
    int gnt_mode = 0;
    int err_at = -1;
    int cyc = 0;
    int beat_cnt, n_words, n_bytew, head_b, tail_b, cur_run, max_run, n_short, n_runs;
    int req_rises, req_cycles, n_done, n_err, done_val, bad_be;
    bit prev_req = 1'b0;

    task automatic clear_stats();
        beat_cnt = 0; n_words = 0; n_bytew = 0; head_b = 0; tail_b = 0;
        cur_run = 0; max_run = 0; n_short = 0; n_runs = 0; req_rises = 0;
        req_cycles = 0; n_done = 0; n_err = 0; done_val = -1; bad_be = 0;
    endtask

    always @(negedge clk) begin
        cyc++;
        bus_gnt = (gnt_mode == 0) ? 1'b1 : cyc[0];
        bus_err = (err_at >= 0) && (beat_cnt == err_at);
        #1;
        if (bus_req) req_cycles++;
        if (bus_req && !prev_req) req_rises++;
        if (bus_req && bus_gnt) begin
            if (!bus_err) begin
                for (int l = 0; l < 4; l++)
                    if (bus_be[l]) mem[{bus_addr[9:2], 2'b00} + l] = bus_wdata[8*l +: 8];
                if (bus_be == 4'b1111) begin
                    if (bus_addr[1:0] != 2'b00) bad_be++;
                    n_words++; cur_run++; tail_b = 0;
                end else begin
                    if (bus_be != (4'b0001 << bus_addr[1:0])) bad_be++;
                    n_bytew++; tail_b++;
                    if (n_words == 0) head_b++;
                end
            end
            beat_cnt++;
        end
        if (!bus_req && prev_req && cur_run > 0) begin
            n_runs++;
            if (cur_run > max_run) max_run = cur_run;
            if (cur_run < BURST) n_short++;
            cur_run = 0;
        end
        prev_req = bus_req;
        if (done) begin n_done++; done_val = int'(done_bytes); end
        if (err) n_err++;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'(seed * 7 + k * 13 + 1);
    endfunction

    task automatic clear_mem(input int addr, input int len);
        for (int j = addr; j < addr + len + 8; j++) mem[j % 1024] = 8'h00;
    endtask

    task automatic push_bytes(input int seed, input int first, input int n, input bit eop_last);
        int k = 0;
        while (k < n) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_byte  = pat(seed, first + k);
            rx_eop   = eop_last && (k == n - 1);
            if (rx_ready) k++;
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_eop   = 1'b0;
    endtask

    task automatic start_pkt(input int addr);
        @(negedge clk);
        start = 1'b1;
        start_addr = 32'(addr);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end();
        int t = 0;
        while (n_done + n_err == 0 && t < 3000) begin
            @(posedge clk);
            t++;
        end
        repeat (4) @(posedge clk);
    endtask

    task automatic verify_pkt(input int addr, input int len, input int seed, input string tag);
        int h, w, tl, mism;
        h = (4 - (addr % 4)) % 4;
        if (h > len) h = len;
        w = (len - h) / 4;
        tl = (len - h) % 4;
        mism = 0;
        for (int j = 0; j < len; j++) if (mem[(addr + j) % 1024] !== pat(seed, j)) mism++;
        chk({tag, " R2 data mismatches"}, mism, 0);
        chk({tag, " R4 head byte writes"}, head_b, h);
        chk({tag, " R2 word beats"}, n_words, w);
        if (w > 0) chk({tag, " R5 tail byte writes"}, tail_b, tl);
        chk({tag, " R4 byte-lane enables"}, bad_be, 0);
        chk({tag, " R7 one request per transfer"}, req_rises, n_runs + n_bytew);
        chk({tag, " R8 done pulses"}, n_done, 1);
        chk({tag, " R8 done_bytes"}, done_val, len);
        chk({tag, " R9 no error"}, n_err, 0);
        chk({tag, " R2 burst not above DEPTH/2"}, int'(max_run <= BURST), 1);
    endtask

    task automatic run_packet(input int addr, input int len, input int seed, input string tag);
        clear_stats();
        clear_mem(addr, len);
        start_pkt(addr);
        push_bytes(seed, 0, len, 1'b1);
        wait_end();
        verify_pkt(addr, len, seed, tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R11 rx_ready after reset", int'(rx_ready), 1);
        chk("R11 bus_req after reset", int'(bus_req), 0);
        chk("R11 done after reset", int'(done), 0);
        chk("R11 err after reset", int'(err), 0);
    endtask

    task automatic t_aligned_long();
        run_packet(32'h100, 100, 1, "aligned100");
        chk("R2 full burst length", max_run, BURST);
        chk("R3 at least one short flush burst", int'(n_short >= 1), 1);
    endtask

    task automatic t_unaligned();
        run_packet(32'h203, 23, 2, "addr203");
        run_packet(32'h0A2, 13, 3, "addr0A2");
        run_packet(32'h301, 2, 4, "short2");
        chk("R4 short packet all single bytes", n_bytew, 2);
    endtask

    task automatic t_slow_grant();
        gnt_mode = 1;
        run_packet(32'h041, 70, 5, "slowgnt");
        chk("R2 full burst under slow grant", max_run, BURST);
        gnt_mode = 0;
    endtask

    task automatic t_threshold();
        clear_stats();
        clear_mem(32'h180, 21);
        start_pkt(32'h180);
        push_bytes(6, 0, 20, 1'b0);
        repeat (30) @(posedge clk);
        chk("R1 no request below half full", req_cycles, 0);
        push_bytes(6, 20, 1, 1'b1);
        wait_end();
        verify_pkt(32'h180, 21, 6, "flush21");
        chk("R6 flushed words", n_words, 5);
    endtask

    task automatic t_error();
        clear_stats();
        push_bytes(7, 0, 40, 1'b1);
        err_at = 3;
        start_pkt(32'h000);
        wait_end();
        err_at = -1;
        chk("R9 err pulses", n_err, 1);
        chk("R9 no done on error", n_done, 0);
        chk("R9 store emptied", int'(rx_ready), 1);
        repeat (20) @(posedge clk);
        chk("R9 no request after abort", int'(bus_req), 0);
        run_packet(32'h2C0, 12, 8, "after_err R9");
    endtask

    task automatic t_full();
        clear_stats();
        clear_mem(32'h380, 64);
        push_bytes(9, 0, 64, 1'b1);
        chk("R10 rx_ready low when full", int'(rx_ready), 0);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = 8'hEE; rx_eop = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; rx_eop = 1'b0;
        clear_stats();
        start_pkt(32'h380);
        wait_end();
        verify_pkt(32'h380, 64, 9, "full64");
        chk("R10 byte offered when full not written", int'(mem[32'h3C0]), 0);
    endtask

    initial begin
        clear_stats();
        for (int j = 0; j < 1024; j++) mem[j] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_aligned_long();
        t_unaligned();
        t_slow_grant();
        t_threshold();
        t_error();
        t_full();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule